// File: doc/BRIEF.md
# PC System Control Port Logic

This block is the keyboard and system-status glue that sits behind a PC-style three-port peripheral interface. The CPU reaches it over a small byte-wide register bus. It has a 2-bit address, an 8-bit write data bus with a write strobe, and a combinational read data output. The block latches one control byte and uses that byte to steer what the two readable ports return.

Address 0 is the keyboard/switch port. It returns the keyboard scan byte while the keyboard is enabled. While the keyboard is disabled it returns the equipment switch byte instead. Address 1 is the control latch. Its bits drive the speaker gate and speaker data, the keyboard clock enable and keyboard disable. A write that disables the keyboard also sends a one-cycle clear pulse to the keyboard interface. One control bit picks which half of the switch byte shows on the status port at address 2. Address 3 holds nothing.

The switch byte uses this layout:

- Bits 7:6: floppy drive count.
- Bits 5:4: display mode. 11 is monochrome, 10 is colour 80x25 and 01 is colour 40x25.
- Bits 3:2: system-board memory bank count.
- Bit 0: 0 when no floppy drive is fitted.

Top module: `sysctl_port_top`

## Requirements
- R1: After reset, all control bits are 0: speaker gate, speaker data, keyboard clock enable, nibble select and keyboard disable. `kbd_clr` is 0, and a read of address 0 returns `kbd_scan`.
- R2: A read of address 0 returns `equip_sw` while control bit 7 is 1, and returns `kbd_scan` while it is 0.
- R3: Each write to address 1 with data bit 7 at 1 makes `kbd_clr` high for exactly the clock cycle after the write edge. A write with bit 7 at 0, or to any other address, gives no pulse.
- R4: Read bits 3:0 of address 2 equal `equip_sw[7:4]` when control bit 3 is 1, and `equip_sw[3:0]` when it is 0.
- R5: Read bits 7:6 of address 2 are always 0, and bits 5:4 are always 1.
- R6: Data bit 0 written to address 1 drives `spk_gate`, and data bit 1 drives `spk_data`. Both take effect from the write edge.
- R7: Data bit 6 written to address 1 drives `kbd_clk_en` from the write edge.
- R8: Reads of address 1 and address 3 return 0xFF.
- R9: Writes to addresses 0, 2 and 3 leave every control output and both read multiplexers unchanged.
- R10: The control state holds between writes. A cycle with `bus_wr` low and address 1 on the bus changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register address: 0 keyboard/switch, 1 control, 2 status, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| kbd_scan | input | 8 | Scan byte from the keyboard interface |
| equip_sw | input | 8 | Equipment switch byte |
| spk_gate | output | 1 | Speaker timer gate (control bit 0) |
| spk_data | output | 1 | Speaker data enable (control bit 1) |
| kbd_clk_en | output | 1 | Keyboard clock enable (control bit 6) |
| kbd_clr | output | 1 | One-cycle keyboard clear pulse |

## Verification
All 256 control bytes are written in turn. Each one is followed by reads with several switch patterns: all zeros, all ones, alternating bits, mixed nibbles, and a pattern equal to the control byte. The scan byte is set to the inverse of the control byte, so a wrong port A source or a wrong switch nibble is always visible. Writes of inverted data to the other three addresses, and idle cycles with the strobe low, separate real decoding from accidental capture. A reset in the middle of the run shows that the asynchronous clear takes effect.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int NIB_W     = DATA_W / 2;

  // control byte bit positions (address 1)
  localparam int CB_SPK_GATE = 0;
  localparam int CB_SPK_DATA = 1;
  localparam int CB_NIB_HI   = 3;
  localparam int CB_KBD_CLK  = 6;
  localparam int CB_KBD_OFF  = 7;

  // fixed upper nibble of the status port: errors clear, bits 5:4 set
  localparam logic [NIB_W-1:0] STATUS_FIXED = 4'b0011;
  localparam logic [DATA_W-1:0] IDLE_READ   = '1;

  typedef enum logic [ADDR_W-1:0] {
    PSEL_KEYSW  = 2'd0,
    PSEL_CTRL   = 2'd1,
    PSEL_STATUS = 2'd2,
    PSEL_SPARE  = 2'd3
  } port_sel_e;

  typedef struct packed {
    logic kbd_off;
    logic kbd_clk;
    logic nib_hi;
    logic spk_data;
    logic spk_gate;
  } ctl_t;
endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sysctl_ctl_reg.sv
module sysctl_ctl_reg
  import sysctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  ctl_t wr_fields,
  output ctl_t ctl,
  output logic clr_pulse
);
  ctl_t ctl_q, ctl_d;
  logic ctl_en;
  logic clr_q, clr_d;

  // next state
  always_comb begin
    ctl_en = wr_ctrl;
    ctl_d  = wr_fields;
    clr_d  = wr_ctrl & wr_fields.kbd_off;
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_d;
  end

  assign ctl       = ctl_q;
  assign clr_pulse = clr_q;

  assert_clr_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_fields.kbd_off) |=> clr_pulse);
  assert_clr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && wr_fields.kbd_off) |=> !clr_pulse);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctl));
  assert_spk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctl.spk_gate == $past(wr_fields.spk_gate)) &&
                (ctl.spk_data == $past(wr_fields.spk_data)));
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
  import sysctl_pkg::*;
(
  input  port_sel_e         sel,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] kbd_scan,
  input  logic [DATA_W-1:0] equip_sw,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] keysw_byte;
  logic [NIB_W-1:0]  sw_nibble;
  logic [DATA_W-1:0] status_byte;

  always_comb begin
    keysw_byte  = ctl.kbd_off ? equip_sw : kbd_scan;
    sw_nibble   = ctl.nib_hi ? equip_sw[DATA_W-1:NIB_W] : equip_sw[NIB_W-1:0];
    status_byte = {STATUS_FIXED, sw_nibble};
    unique case (sel)
      PSEL_KEYSW:  rdata = keysw_byte;
      PSEL_STATUS: rdata = status_byte;
      default:     rdata = IDLE_READ;
    endcase
  end
endmodule

// File: rtl/sysctl_port_top.sv
module sysctl_port_top
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  output logic [7:0] bus_rdata,
  input  logic [7:0] kbd_scan,
  input  logic [7:0] equip_sw,
  output logic       spk_gate,
  output logic       spk_data,
  output logic       kbd_clk_en,
  output logic       kbd_clr
);
  logic      rst_sync_n;
  port_sel_e sel;
  logic      wr_ctrl;
  ctl_t      wr_fields;
  ctl_t      ctl;
  logic      unused_wdata_bits;

  sysctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel                = port_sel_e'(bus_addr);
    wr_ctrl            = bus_wr && (sel == PSEL_CTRL);
    wr_fields.kbd_off  = bus_wdata[CB_KBD_OFF];
    wr_fields.kbd_clk  = bus_wdata[CB_KBD_CLK];
    wr_fields.nib_hi   = bus_wdata[CB_NIB_HI];
    wr_fields.spk_data = bus_wdata[CB_SPK_DATA];
    wr_fields.spk_gate = bus_wdata[CB_SPK_GATE];
  end

  assign unused_wdata_bits = ^{bus_wdata[5:4], bus_wdata[2]};

  sysctl_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_ctrl   (wr_ctrl),
    .wr_fields (wr_fields),
    .ctl       (ctl),
    .clr_pulse (kbd_clr)
  );

  sysctl_rd_mux u_mux (
    .sel      (sel),
    .ctl      (ctl),
    .kbd_scan (kbd_scan),
    .equip_sw (equip_sw),
    .rdata    (bus_rdata)
  );

  assign spk_gate   = ctl.spk_gate;
  assign spk_data   = ctl.spk_data;
  assign kbd_clk_en = ctl.kbd_clk;

  assert_status_fixed_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 2'd2) |-> (bus_rdata[7:4] == 4'b0011));
  assert_keysw_switch_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 2'd0 && $past(bus_wr && bus_addr == 2'd1 && bus_wdata[7]))
      |-> (bus_rdata == equip_sw));
  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr[0]) |-> (bus_rdata == 8'hFF));
  assert_other_wr_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr != 2'd1) |=> $stable({spk_gate, spk_data, kbd_clk_en}) && !kbd_clr);
  assert_clk_en_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == 2'd1) |=> (kbd_clk_en == $past(bus_wdata[6])));
endmodule

// File: tb/sysctl_port_top_test.sv
module sysctl_port_top_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic [7:0] bus_rdata;
  logic [7:0] kbd_scan;
  logic [7:0] equip_sw;
  logic       spk_gate, spk_data, kbd_clk_en, kbd_clr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  sysctl_port_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .kbd_scan(kbd_scan),
    .equip_sw(equip_sw), .spk_gate(spk_gate), .spk_data(spk_data),
    .kbd_clk_en(kbd_clk_en), .kbd_clr(kbd_clr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // drive a one-cycle write, return at the negedge after the capturing edge
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] outs_of(input logic [7:0] b);
    return {5'b0, b[6], b[1], b[0]};
  endfunction

  function automatic logic [7:0] status_exp(input logic [7:0] b, input logic [7:0] sw);
    return {4'b0011, b[3] ? sw[7:4] : sw[3:0]};
  endfunction

  task automatic check_reads(input logic [7:0] b);
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h3C; pats[5] = b;
    kbd_scan = ~b;
    for (int i = 0; i < 6; i++) begin
      equip_sw = pats[i];
      bus_addr = 2'd0; #1;
      chk("R2 port A", bus_rdata, b[7] ? pats[i] : ~b);
      bus_addr = 2'd2; #1;
      chk("R4 status nibble", bus_rdata, status_exp(b, pats[i]));
      chk("R5 status fixed bits", {bus_rdata[7:4], 4'h0}, 8'h30);
    end
    bus_addr = 2'd1; #1;
    chk("R8 ctrl read", bus_rdata, 8'hFF);
    bus_addr = 2'd3; #1;
    chk("R8 spare read", bus_rdata, 8'hFF);
  endtask

  task automatic check_outs(input string req, input logic [7:0] b);
    chk(req, {5'b0, kbd_clk_en, spk_data, spk_gate}, outs_of(b));
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b0;
    kbd_scan = 8'h96; equip_sw = 8'h4D;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_outs("R1 reset outputs", 8'h00);
    chk("R1 reset clear", {7'b0, kbd_clr}, 8'h00);
    bus_addr = 2'd0; #1;
    chk("R1 reset port A", bus_rdata, 8'h96);

    for (int b = 0; b < 256; b++) begin
      logic [7:0] bv;
      bv = b[7:0];
      bus_write(2'd1, bv);
      check_outs("R6 R7 control outputs", bv);
      chk("R3 clear pulse", {7'b0, kbd_clr}, {7'b0, bv[7]});
      @(negedge clk);
      chk("R3 clear single cycle", {7'b0, kbd_clr}, 8'h00);
      check_reads(bv);

      // R9: writes elsewhere with inverted data
      for (int a = 0; a < 4; a++) begin
        if (a == 1) continue;
        bus_write(a[1:0], ~bv);
        chk("R9 no clear from other address", {7'b0, kbd_clr}, 8'h00);
        check_outs("R9 other-address write ignored", bv);
      end
      check_reads(bv);

      // R10: strobe low on control address
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = ~bv; bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      check_outs("R10 hold without strobe", bv);
      chk("R10 no clear without strobe", {7'b0, kbd_clr}, 8'h00);
    end

    // R1 asynchronous reset mid-run
    bus_write(2'd1, 8'hCB);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check_outs("R1 async reset outputs", 8'h00);
    kbd_scan = 8'h21; equip_sw = 8'hE7; bus_addr = 2'd0; #1;
    chk("R1 async reset port A", bus_rdata, 8'h21);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outs("R1 after release", 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_200_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule